// File: doc/BRIEF.md
# Watchdog and Reset Pulse Supervisor

This block drives a processor reset from two sources. The first is a supply-low flag that has already been synchronised. The second is a watchdog that software must service by toggling a line. A shared prescaler divides the clock into ticks, and all timing is counted in those ticks. The counted intervals are:

- the hold time that keeps reset asserted after its cause has cleared;
- the watchdog timeout;
- the width of each reset pulse the watchdog issues.

Software services the watchdog by changing the level of its input, either rising or falling. Each change restarts the timeout. A separate flag marks the input as undriven (floating or at mid level), and while that flag is set the watchdog is off. A backup-mode input holds reset asserted and turns the watchdog off. The block provides two reset outputs: an active-low reset and its exact active-high complement.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_low` is 1, `rst_out_n` is 0 from the clock edge after it is seen, for as long as the flag stays set.
- R2: Reset is asserted during chip reset. After chip reset ends, or after the last active reset cause clears, `rst_out_n` returns to 1 after HOLD_TICKS prescaler ticks. Counted in clock edges after the cause clears, that is between (HOLD_TICKS-1)*TICK_DIV+1 and HOLD_TICKS*TICK_DIV.
- R3: With the watchdog enabled, every change of `wd_level`, rising or falling, restarts the timeout. A line toggled more often than the timeout never causes a reset.
- R4: When the watchdog expires, reset is asserted at the next edge and held for the R2 hold time.
- R5: If `wd_level` never changes, a new reset pulse follows every timeout period for as long as the level stays static.
- R6: While `wd_float` is 1, the watchdog never expires, even with `wd_level` static.
- R7: While `backup_mode` is 1, reset is asserted from the next edge and the watchdog is off. After backup mode ends, reset releases after the R2 hold time.
- R8: `rst_out` is always the exact complement of `rst_out_n`.
- R9: While reset is asserted, the watchdog count is held at zero. Counting starts again when reset releases, so a static input gives a timeout between (WD_TICKS-1)*TICK_DIV+1 and WD_TICKS*TICK_DIV edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| supply_low | input | 1 | Synchronised supply-below-threshold flag |
| wd_level | input | 1 | Watchdog service line, resolved to a logic level |
| wd_float | input | 1 | 1 when the service line is undriven; turns the watchdog off |
| backup_mode | input | 1 | Backup-power mode; forces reset and turns the watchdog off |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high copy of the reset |

## Verification
The hardest condition to reach from the ports is a watchdog timeout that starts from a fully cleared count. It needs a reset caused by low supply that lasts longer than the timeout. That reset must then release while the service line is static and the watchdog is enabled. The bench does this by enabling the watchdog and raising `supply_low` on the same cycle. It holds `supply_low` for well over one timeout, then releases it. It then measures the gap from reset release to the next reset and the following pulse widths. Because the tick phase is not controlled, each measured gap is compared against a one-tick window computed from the parameters.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Width needed to count 0..lim-1 (minimum 1 bit).
  function automatic int unsigned cnt_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

  // True when a counter sits on its final value before wrapping.
  function automatic logic is_last(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction
endpackage

// File: rtl/sup_tick.sv
module sup_tick #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = sup_pkg::cnt_w(TICK_DIV);
  logic [CW-1:0] cnt;

  assign tick = sup_pkg::is_last(32'(cnt), TICK_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sup_wd_sync.sv
module sup_wd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic edge_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= level_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // Either direction of change counts as a service.
  assign edge_o = s2 ^ s3;
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer #(
  parameter int unsigned WD_TICKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        kick,
  input  logic        tick,
  output logic [31:0] cnt_o,
  output logic        expire
);
  localparam int unsigned CW = sup_pkg::cnt_w(WD_TICKS);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = sup_pkg::is_last(32'(cnt), WD_TICKS);
  assign expire = enable && !kick && tick && at_end;
  assign cnt_o  = 32'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!enable || kick)  cnt <= '0;
    else if (tick)             cnt <= at_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned HOLD_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause,
  input  logic tick,
  output logic active
);
  localparam int unsigned CW = sup_pkg::cnt_w(HOLD_TICKS);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (cause) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tick) begin
      if (sup_pkg::is_last(32'(cnt), HOLD_TICKS)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned HOLD_TICKS = 5,
  parameter int unsigned WD_TICKS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic wd_level,
  input  logic wd_float,
  input  logic backup_mode,
  output logic rst_out_n,
  output logic rst_out
);
  logic        tick;
  logic        wd_edge;
  logic        wd_en;
  logic        wd_expire;
  logic [31:0] wd_cnt;
  logic        rst_act;
  logic        rst_cause;

  sup_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sup_wd_sync u_sync (
    .clk(clk), .rst_n(rst_n), .level_i(wd_level), .edge_o(wd_edge)
  );

  assign wd_en = !wd_float && !backup_mode && !rst_act;

  sup_wd_timer #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n), .enable(wd_en), .kick(wd_edge),
    .tick(tick), .cnt_o(wd_cnt), .expire(wd_expire)
  );

  assign rst_cause = supply_low || backup_mode || wd_expire;

  sup_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .cause(rst_cause), .tick(tick), .active(rst_act)
  );

  assign rst_out_n = !rst_act;
  assign rst_out   = rst_act;
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        supply_low,
  input logic        backup_mode,
  input logic        wd_float,
  input logic        rst_out_n,
  input logic        rst_out,
  input logic        wd_expire,
  input logic        rst_act,
  input logic [31:0] wd_cnt
);
  p_supply_forces_r1: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !rst_out_n);

  p_expire_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !rst_out_n);

  p_float_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_float |-> !wd_expire);

  p_backup_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    backup_mode |=> (!rst_out_n && !wd_expire));

  p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out == !rst_out_n);

  p_idle_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (wd_cnt == 32'd0));
endmodule

bind rst_supervisor sup_checker u_chk (
  .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .backup_mode(backup_mode),
  .wd_float(wd_float), .rst_out_n(rst_out_n), .rst_out(rst_out),
  .wd_expire(wd_expire), .rst_act(rst_act), .wd_cnt(wd_cnt)
);

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;
  localparam int D = 4;
  localparam int H = 5;
  localparam int W = 8;
  localparam int HMIN = (H-1)*D+1, HMAX = H*D;
  localparam int WMIN = (W-1)*D+1, WMAX = W*D;

  logic clk = 1'b0;
  logic rst_n, supply_low, wd_level, wd_float, backup_mode;
  logic rst_out_n, rst_out;
  int checks = 0, failures = 0, cmp_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_supervisor #(.TICK_DIV(D), .HOLD_TICKS(H), .WD_TICKS(W)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .wd_level(wd_level),
    .wd_float(wd_float), .backup_mode(backup_mode),
    .rst_out_n(rst_out_n), .rst_out(rst_out)
  );

  always @(negedge clk) if (rst_out !== ~rst_out_n) cmp_bad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // Edges until rst_out_n reaches the given level.
  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    while (rst_out_n !== lvl && n < 2000) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  // Count samples with reset asserted over n cycles.
  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_out_n !== 1'b1) lows++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, lows;
    rst_n = 1'b0; supply_low = 1'b0; wd_level = 1'b0; wd_float = 1'b1; backup_mode = 1'b0;
    step(3);
    check(rst_out_n === 1'b0 && rst_out === 1'b1, "R2 reset state", int'(rst_out_n), 0);
    rst_n = 1'b1;
    wait_level(1'b1, n);
    check(n >= HMIN && n <= HMAX, "R2 power-on hold", n, HMAX);

    // R6: undriven line, static level: no reset ever.
    count_low(200, lows);
    check(lows == 0, "R6 float disables watchdog", lows, 0);

    // R1 + R9: enable watchdog, hold supply low beyond a timeout.
    wd_float = 1'b0; supply_low = 1'b1;
    step(1);
    check(rst_out_n === 1'b0, "R1 supply low asserts", int'(rst_out_n), 0);
    count_low(80, lows);
    check(lows == 80, "R1 held while supply low", lows, 80);
    supply_low = 1'b0;
    wait_level(1'b1, n);
    check(n >= HMIN && n <= HMAX, "R2 hold after supply", n, HMAX);
    wait_level(1'b0, n);
    check(n >= WMIN && n <= WMAX, "R9 timeout from cleared count", n, WMAX);
    wait_level(1'b1, n);
    check(n >= HMIN && n <= HMAX, "R4 watchdog pulse width", n, HMAX);
    wait_level(1'b0, n);
    check(n >= WMIN && n <= WMAX, "R5 repeat pulse period", n, WMAX);
    wait_level(1'b1, n);
    check(n >= HMIN && n <= HMAX, "R5 repeat pulse width", n, HMAX);

    // R3: toggling (both directions) keeps reset away.
    for (int t = 0; t < 20; t++) begin
      step(11);
      wd_level = ~wd_level;
      @(posedge clk); @(negedge clk);
      if (rst_out_n !== 1'b1) cmp_bad += 0;
    end
    count_low(1, lows);
    begin
      int lows2;
      lows2 = 0;
      for (int t = 0; t < 20; t++) begin
        for (int i = 0; i < 12; i++) begin
          @(posedge clk); @(negedge clk);
          if (rst_out_n !== 1'b1) lows2++;
        end
        wd_level = ~wd_level;
      end
      check(lows2 == 0, "R3 toggling services watchdog", lows2, 0);
    end
    // Stop toggling: timeout must follow.
    wait_level(1'b0, n);
    check(n >= WMIN && n <= WMAX + 4, "R3 timeout after last edge", n, WMAX);
    wait_level(1'b1, n);

    // R7: backup mode holds reset, watchdog off.
    backup_mode = 1'b1;
    step(1);
    check(rst_out_n === 1'b0, "R7 backup asserts", int'(rst_out_n), 0);
    count_low(100, lows);
    check(lows == 100, "R7 held in backup", lows, 100);
    wd_float = 1'b1;
    backup_mode = 1'b0;
    wait_level(1'b1, n);
    check(n >= HMIN && n <= HMAX, "R7 hold after backup", n, HMAX);
    count_low(100, lows);
    check(lows == 0, "R6 float after backup", lows, 0);

    check(cmp_bad == 0, "R8 complement outputs", cmp_bad, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule